// File: doc/BRIEF.md
# Leading-Miss Interval Detector

This block sits beside the miss-status holding registers of a second-level cache. It sees every allocate and every free strobe, each with its entry index. From these it keeps an occupancy count and a valid bit per entry. Each new miss is classed as leading or overlapped. A miss is leading when no other miss is outstanding at the moment it is allocated. That covers an isolated miss and the first miss of a burst. A miss allocated while others are pending is overlapped and starts nothing.

Two saturating counters feed a frequency-scaling performance model. One counts leading misses. The other counts the cycles during which a leading miss is outstanding. The index of the current leading miss is latched. Its interval ends only when that same entry is freed, whatever happens to the overlapped misses around it. A measurement window gates both counters. Opening the window clears them, and closing it freezes them. A free strobe aimed at an entry that holds no miss sets a sticky error flag.

There are two state machines. The window machine has states WIN_CLOSED and WIN_OPEN, with transitions `open` (start strobe, taken from either state), `close` (stop strobe while open) and `hold`. The tracking machine has states LEAD_IDLE and LEAD_TRACK, with transitions `lead_alloc` (an allocate at zero occupancy, from LEAD_IDLE) and `lead_free` (a valid free of the latched index, from LEAD_TRACK).

Top module: `leading_miss_monitor`

## Requirements
- R1: Occupancy rises by one for an allocate and falls by one for a free of a valid entry. An allocate and a valid free in the same cycle, including to the same index, leave it unchanged. The `occupancy` output shows the new value one cycle after the strobes.
- R2: An allocate sampled while occupancy is zero is a leading miss and adds one to `lead_cnt`. An allocate sampled while occupancy is non-zero adds nothing.
- R3: For a leading miss allocated in cycle k whose own entry is freed in cycle m, `lead_cyc` grows by m-k. Frees of other entries in between do not end the interval.
- R4: Once the leading entry is freed, `lead_cyc` stops even if overlapped misses remain. Misses allocated while those remain start no new interval.
- R5: A free strobe for an entry whose valid bit is clear sets `free_err`, which stays set until reset. That strobe changes neither occupancy nor any entry state.
- R6: A start strobe clears both counters to zero and opens the window, with priority over a stop strobe in the same cycle. Events in the start cycle are not counted.
- R7: Counting happens only in cycles sampled while the window is open. Events in the stop cycle are still counted. After the stop cycle both counters hold their values.
- R8: Each counter saturates at 2^CNT_W-1 and does not wrap.
- R9: After reset both counters, the occupancy and `free_err` are zero, and the window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Miss register allocate strobe |
| alloc_idx | input | IDX_W | Entry index being allocated |
| free_vld | input | 1 | Miss register free strobe |
| free_idx | input | IDX_W | Entry index being freed |
| win_start | input | 1 | Clear counters and open the window |
| win_stop | input | 1 | Close the window |
| lead_cnt | output | CNT_W | Leading misses counted in the window |
| lead_cyc | output | CNT_W | Cycles with a leading miss outstanding |
| occupancy | output | OCC_W | Number of outstanding misses |
| free_err | output | 1 | Sticky flag for a free of an empty entry |

## Verification
Every result is registered. Occupancy, the error flag and both counters therefore show the effect of strobes sampled at one edge from that edge onward. The one exception is an interval's cycle count, which grows at every edge after the leading allocate, up to and including the edge that samples its free. The bench drives each cycle's strobes at the falling edge, and a reference model steps at the next rising edge. At the falling edge after that, the model pushes its expected values into a queue. A monitor pops each item and compares it with the outputs, so every cycle is checked exactly when its result is due.

// File: rtl/mld_pkg.sv
package mld_pkg;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_e;

    typedef enum logic {
        LEAD_IDLE  = 1'b0,
        LEAD_TRACK = 1'b1
    } lead_state_e;

endpackage

// File: rtl/mld_entry_track.sv
module mld_entry_track #(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_vld,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             free_vld,
    input  logic [IDX_W-1:0] free_idx,
    output logic             free_ok,
    output logic [OCC_W-1:0] occ,
    output logic             err
);

    logic [N-1:0]     valid_q;
    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] occ_d;
    logic             err_q;
    logic             free_in_range;
    logic             free_bad;

    assign free_in_range = (32'(free_idx) < N);
    assign free_ok       = free_vld && free_in_range && valid_q[free_idx];
    assign free_bad      = free_vld && !free_ok;

    // per-entry valid bits: a free clears, an allocate sets (allocate wins)
    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (alloc_vld && (alloc_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
            end else if (free_ok && (free_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        occ_d = occ_q;
        unique case ({alloc_vld, free_ok})
            2'b10:   occ_d = occ_q + OCC_W'(1);
            2'b01:   occ_d = occ_q - OCC_W'(1);
            default: occ_d = occ_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
            err_q <= 1'b0;
        end else begin
            occ_q <= occ_d;
            if (free_bad) begin
                err_q <= 1'b1;
            end
        end
    end

    assign occ = occ_q;
    assign err = err_q;

    // R1: occupancy agrees with the number of valid entries
    a_r1_occ_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occ_q) == $countones(valid_q));

    // R5: a bad free alone leaves occupancy as it was
    a_r5_bad_free_no_occ: assert property (@(posedge clk) disable iff (!rst_n)
        (free_bad && !alloc_vld) |=> (occ_q == $past(occ_q)));

    // R5: error flag is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/mld_lead_fsm.sv
module mld_lead_fsm #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_vld,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             occ_zero,
    input  logic             free_ok,
    input  logic [IDX_W-1:0] free_idx,
    output logic             lead_start,
    output logic             lead_busy
);

    import mld_pkg::*;

    lead_state_e      state_q, state_d;
    logic [IDX_W-1:0] lead_idx_q;

    assign lead_start = alloc_vld && occ_zero;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEAD_IDLE:  if (lead_start) state_d = LEAD_TRACK;
            LEAD_TRACK: if (free_ok && (free_idx == lead_idx_q)) state_d = LEAD_IDLE;
            default:    state_d = LEAD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEAD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_idx_q <= '0;
        end else if (lead_start) begin
            lead_idx_q <= alloc_idx;
        end
    end

    assign lead_busy = (state_q == LEAD_TRACK);

    // R4: a tracked leading miss implies outstanding occupancy
    a_r4_busy_needs_occ: assert property (@(posedge clk) disable iff (!rst_n)
        lead_busy |-> !occ_zero);

    // R2: a leading allocate always enters tracking
    a_r2_lead_enters_track: assert property (@(posedge clk) disable iff (!rst_n)
        lead_start |=> lead_busy);

endmodule

// File: rtl/mld_win_fsm.sv
module mld_win_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic win_start,
    input  logic win_stop,
    output logic count_en,
    output logic clr
);

    import mld_pkg::*;

    win_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_CLOSED: if (win_start) state_d = WIN_OPEN;
            WIN_OPEN: begin
                if (win_start)     state_d = WIN_OPEN;
                else if (win_stop) state_d = WIN_CLOSED;
            end
            default: state_d = WIN_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_en = (state_q == WIN_OPEN);
    assign clr      = win_start;

    // R6: start opens the window even with a stop in the same cycle
    a_r6_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> count_en);

    // R7: stop without start closes the window
    a_r7_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (win_stop && !win_start) |=> !count_en);

endmodule

// File: rtl/mld_sat_cnt.sv
module mld_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (clr) begin
            value_q <= '0;
        end else if (inc && (value_q != MAXV)) begin
            value_q <= value_q + W'(1);
        end
    end

    assign value = value_q;

    // R6: clear empties the counter
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value_q == '0));

    // R8: a full counter never wraps
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (value_q == MAXV && !clr) |=> (value_q == MAXV));

    // R7: without increment or clear the counter holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(value_q));

endmodule

// File: rtl/leading_miss_monitor.sv
module leading_miss_monitor #(
    parameter int N     = 8,
    parameter int CNT_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int OCC_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_vld,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             free_vld,
    input  logic [IDX_W-1:0] free_idx,
    input  logic             win_start,
    input  logic             win_stop,
    output logic [CNT_W-1:0] lead_cnt,
    output logic [CNT_W-1:0] lead_cyc,
    output logic [OCC_W-1:0] occupancy,
    output logic             free_err
);

    logic free_ok;
    logic lead_start;
    logic lead_busy;
    logic count_en;
    logic clr;

    mld_entry_track #(.N(N), .IDX_W(IDX_W), .OCC_W(OCC_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vld (alloc_vld),
        .alloc_idx (alloc_idx),
        .free_vld  (free_vld),
        .free_idx  (free_idx),
        .free_ok   (free_ok),
        .occ       (occupancy),
        .err       (free_err)
    );

    mld_lead_fsm #(.IDX_W(IDX_W)) u_lead (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_vld  (alloc_vld),
        .alloc_idx  (alloc_idx),
        .occ_zero   (occupancy == '0),
        .free_ok    (free_ok),
        .free_idx   (free_idx),
        .lead_start (lead_start),
        .lead_busy  (lead_busy)
    );

    mld_win_fsm u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_start (win_start),
        .win_stop  (win_stop),
        .count_en  (count_en),
        .clr       (clr)
    );

    mld_sat_cnt #(.W(CNT_W)) u_cnt_lead (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (count_en && lead_start),
        .value (lead_cnt)
    );

    mld_sat_cnt #(.W(CNT_W)) u_cnt_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (count_en && lead_busy),
        .value (lead_cyc)
    );

    // R2: an allocate while misses are pending does not bump the leading count
    a_r2_overlap_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_vld && occupancy != '0 && !win_start) |=> (lead_cnt == $past(lead_cnt)));

endmodule

// File: tb/leading_miss_monitor_tb_top.sv
module leading_miss_monitor_tb_top;

    localparam int N     = 8;
    localparam int CNT_W = 8;
    localparam int IDX_W = 3;
    localparam int OCC_W = 4;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_vld = 1'b0;
    logic [IDX_W-1:0] alloc_idx = '0;
    logic             free_vld = 1'b0;
    logic [IDX_W-1:0] free_idx = '0;
    logic             win_start = 1'b0;
    logic             win_stop = 1'b0;
    logic [CNT_W-1:0] lead_cnt;
    logic [CNT_W-1:0] lead_cyc;
    logic [OCC_W-1:0] occupancy;
    logic             free_err;

    always #2 clk = ~clk;

    leading_miss_monitor #(.N(N), .CNT_W(CNT_W)) dut_i (
        .clk, .rst_n, .alloc_vld, .alloc_idx, .free_vld, .free_idx,
        .win_start, .win_stop, .lead_cnt, .lead_cyc, .occupancy, .free_err
    );

    typedef struct {
        string tag;
        int    cnt;
        int    cyc;
        int    occ;
        int    err;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // reference model state
    bit   m_valid[N];
    int   m_occ = 0;
    int   m_err = 0;
    int   m_cnt = 0;
    int   m_cyc = 0;
    bit   m_win = 1'b0;
    bit   m_busy = 1'b0;
    int   m_lidx = 0;

    task automatic step(input bit a, input int ai, input bit f, input int fi,
                        input bit s, input bit p, input string tag);
        bit fok;
        bit lead;
        exp_t e;
        alloc_vld = a; alloc_idx = IDX_W'(ai);
        free_vld  = f; free_idx  = IDX_W'(fi);
        win_start = s; win_stop  = p;
        @(posedge clk);
        fok  = f && m_valid[fi];
        lead = a && (m_occ == 0);
        if (f && !fok) m_err = 1;
        if (s) begin
            m_cnt = 0; m_cyc = 0;
        end else if (m_win) begin
            if (lead && m_cnt < MAXC) m_cnt++;
            if (m_busy && m_cyc < MAXC) m_cyc++;
        end
        if (s) m_win = 1'b1; else if (p) m_win = 1'b0;
        if (m_busy && fok && fi == m_lidx) m_busy = 1'b0;
        if (lead) begin m_busy = 1'b1; m_lidx = ai; end
        if (fok) m_valid[fi] = 1'b0;
        if (a) m_valid[ai] = 1'b1;
        m_occ = m_occ + int'(a) - int'(fok);
        @(negedge clk);
        e.tag = tag; e.cnt = m_cnt; e.cyc = m_cyc; e.occ = m_occ; e.err = m_err;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // monitor: compares each expected item as soon as it is pushed
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            cmp(e.tag, "lead_cnt", int'(lead_cnt), e.cnt);
            cmp(e.tag, "lead_cyc", int'(lead_cyc), e.cyc);
            cmp(e.tag, "occupancy", int'(occupancy), e.occ);
            cmp(e.tag, "free_err", int'(free_err), e.err);
        end
    end

    // watchdog
    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        if (!done) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t e;
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        e.tag = "R9"; e.cnt = 0; e.cyc = 0; e.occ = 0; e.err = 0;
        exp_q.push_back(e);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: events before the window opens are not counted
        step(1, 1, 0, 0, 0, 0, "R7");
        idle(2, "R7");
        step(0, 0, 1, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 0, "R6");
        // R2 R3: isolated miss held for 5 cycles
        step(1, 2, 0, 0, 0, 0, "R2");
        idle(4, "R3");
        step(0, 0, 1, 2, 0, 0, "R3");
        // R3: burst, overlapped entry freed first, leading entry freed later
        step(1, 0, 0, 0, 0, 0, "R2");
        idle(1, "R3");
        step(1, 1, 0, 0, 0, 0, "R2");
        idle(2, "R3");
        step(0, 0, 1, 1, 0, 0, "R3");
        idle(2, "R3");
        step(0, 0, 1, 0, 0, 0, "R3");
        // R4: leading freed while an overlapped miss remains
        step(1, 3, 0, 0, 0, 0, "R2");
        step(1, 4, 0, 0, 0, 0, "R4");
        step(0, 0, 1, 3, 0, 0, "R4");
        idle(3, "R4");
        step(1, 5, 0, 0, 0, 0, "R4");
        idle(2, "R4");
        // R1: allocate and free in one cycle, then same index both
        step(1, 6, 1, 4, 0, 0, "R1");
        step(1, 5, 1, 5, 0, 0, "R1");
        step(0, 0, 1, 5, 0, 0, "R1");
        step(0, 0, 1, 6, 0, 0, "R1");
        // R5: free of an empty entry, then the entry still allocates normally
        step(0, 0, 1, 7, 0, 0, "R5");
        idle(2, "R5");
        step(1, 7, 1, 2, 0, 0, "R5");
        step(0, 0, 1, 7, 0, 0, "R5");
        // R7: leading allocate in the stop cycle is counted; later activity is not
        step(1, 2, 0, 0, 0, 1, "R7");
        idle(3, "R7");
        step(0, 0, 1, 2, 0, 0, "R7");
        step(1, 3, 0, 0, 0, 0, "R7");
        step(0, 0, 1, 3, 0, 0, "R7");
        // R6: start with stop in the same cycle clears and opens; start-cycle lead not counted
        step(1, 4, 0, 0, 1, 1, "R6");
        idle(2, "R6");
        step(0, 0, 1, 4, 0, 0, "R6");
        // R8: saturation of both counters
        for (int i = 0; i < MAXC + 5; i++) begin
            step(1, i % N, 0, 0, 0, 0, "R8");
            step(0, 0, 1, i % N, 0, 0, "R8");
        end
        idle(2, "R8");
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule